// File: doc/BRIEF.md
# Per-Core Transactional Conflict Tracker

This unit sits beside one core's private cache and keeps the bookkeeping a hardware transaction needs to find conflicts as they happen but settle them only when a transaction commits. For each cache line it holds two flags: one for lines the running transaction has read speculatively, and one for lines it has modified speculatively. It also holds two core-indexed bit vectors. The racers vector lists the cores this transaction must abort if it commits first. The killers vector lists the cores whose earlier commit may abort this transaction.

Local read and write events set the line flags. The directory forwards accesses by remote cores to lines this core also holds. Each forwarded access carries the remote core number, the line index and whether it was a write, and it fills the two vectors. At commit the unit sends an abort to every racer in one broadcast mask. It then waits until each of those racers has acknowledged, and only then reports the commit as done. A transaction with no racers commits in the next cycle with no traffic at all, so transactions on disjoint data never wait on one another. An abort that arrives from a registered killer ends the local transaction. Every incoming abort is acknowledged, and an abort from a core that is not a killer is counted as spurious.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset the unit is idle, both vectors, the abort mask and the spurious count are zero, and no completion, abort or acknowledge pulse is raised.
- R2: `tx_begin` moves an idle unit to the active state in the next cycle. Local read and write events set the read and modified flags of `loc_line` only while a transaction is active. Events arriving while idle leave no trace.
- R3: A remote read of a line this transaction has only read records nothing in either vector.
- R4: While active, a remote access of either kind to a line this transaction has modified sets bit `acc_core` of the racers vector one cycle later.
- R5: While active, a remote write to a line this transaction has read or modified sets bit `acc_core` of the killers vector one cycle later. A remote write to a modified line therefore sets both vectors.
- R6: A commit request while active with an empty racers vector raises `tx_committed` for one cycle in the next cycle and drives no abort mask.
- R7: A commit request with a non-empty racers vector drives `abt_out_mask` equal to the racers vector for one cycle in the next cycle, and the unit enters the committing state. Each `ack_in_vld` clears bit `ack_in_src` of the pending set. `tx_committed` pulses one cycle after the cycle in which the last pending bit clears.
- R8: Every `abt_in_vld` is answered one cycle later by `ack_out_vld` with `ack_out_dst` equal to `abt_in_src`.
- R9: An abort from a core whose killers bit is set, arriving while active, raises `tx_aborted` for one cycle in the next cycle. It takes precedence over a commit request in the same cycle.
- R10: An abort from a core whose killers bit is clear has no effect on the transaction, and it raises `spur_cnt` by one. The count saturates at its maximum.
- R11: A commit or abort clears both vectors and all line flags in the same cycle. A later remote write to a line read by the finished transaction sets nothing.
- R12: While committing, an abort from a killer is acknowledged but does not abort the transaction, and the commit still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Start a transaction (idle only) |
| loc_rd | input | 1 | Local speculative read of `loc_line` |
| loc_wr | input | 1 | Local speculative write of `loc_line` |
| loc_line | input | LW | Line index of the local event |
| acc_vld | input | 1 | Remote accessor notification valid |
| acc_core | input | CW | Core number of the remote accessor |
| acc_line | input | LW | Line index the remote core touched |
| acc_wr | input | 1 | 1: remote write, 0: remote read |
| commit_req | input | 1 | Request to commit the active transaction |
| abt_in_vld | input | 1 | Incoming abort message valid |
| abt_in_src | input | CW | Sender of the incoming abort |
| ack_in_vld | input | 1 | Incoming abort acknowledge valid |
| ack_in_src | input | CW | Sender of the acknowledge |
| tx_active | output | 1 | Transaction running, not yet committing |
| tx_committing | output | 1 | Waiting for abort acknowledges |
| racers_vec | output | NCORES | Cores to abort on own commit |
| killers_vec | output | NCORES | Cores that may abort this transaction |
| abt_out_mask | output | NCORES | One-cycle abort broadcast mask |
| ack_out_vld | output | 1 | Outgoing abort acknowledge valid |
| ack_out_dst | output | CW | Destination of the acknowledge |
| tx_committed | output | 1 | One-cycle commit-done pulse |
| tx_aborted | output | 1 | One-cycle local abort pulse |
| spur_cnt | output | CNTW | Saturating count of spurious aborts |

## Verification
Assertions check the following on every cycle: commit and abort never pulse together, both vectors are empty after either pulse, every abort mask equals the racers vector, every incoming abort gets its acknowledgement, a remote read of a line that is not modified leaves both vectors unchanged, and the pending set stays inside the racers vector. Other properties depend on sequences that only the bench's scenarios can set up. These are the ordering of acknowledges ahead of the commit pulse, the precedence of a killer's abort over a commit in the same cycle, the survival of a commit in flight against a late abort, the clearing of line flags seen through later remote writes, and the saturating spurious count. The random phase compares every output in every cycle against a bench model that is driven by mixed local, remote, abort and acknowledge traffic.

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker #(
  parameter int NCORES = 32,
  parameter int NLINES = 16,
  parameter int CNTW   = 8,
  localparam int CW    = $clog2(NCORES),
  localparam int LW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              loc_rd,
  input  logic              loc_wr,
  input  logic [LW-1:0]     loc_line,
  input  logic              acc_vld,
  input  logic [CW-1:0]     acc_core,
  input  logic [LW-1:0]     acc_line,
  input  logic              acc_wr,
  input  logic              commit_req,
  input  logic              abt_in_vld,
  input  logic [CW-1:0]     abt_in_src,
  input  logic              ack_in_vld,
  input  logic [CW-1:0]     ack_in_src,
  output logic              tx_active,
  output logic              tx_committing,
  output logic [NCORES-1:0] racers_vec,
  output logic [NCORES-1:0] killers_vec,
  output logic [NCORES-1:0] abt_out_mask,
  output logic              ack_out_vld,
  output logic [CW-1:0]     ack_out_dst,
  output logic              tx_committed,
  output logic              tx_aborted,
  output logic [CNTW-1:0]   spur_cnt
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} st_t;

  st_t st;
  logic [NLINES-1:0] sr, sm;
  logic [NCORES-1:0] pend;

  wire [NCORES-1:0] abt_bit  = NCORES'(1) << abt_in_src;
  wire [NCORES-1:0] ack_bit  = NCORES'(1) << ack_in_src;
  wire [NCORES-1:0] acc_bit  = NCORES'(1) << acc_core;
  wire              kil_hit  = |(killers_vec & abt_bit);
  wire              do_abort = abt_in_vld && kil_hit && st == S_RUN;
  wire              spur     = abt_in_vld && !kil_hit;
  wire              acc_mod  = sm[acc_line];
  wire              acc_any  = sr[acc_line] | sm[acc_line];
  wire [NCORES-1:0] pend_nx  = pend & ~(ack_in_vld ? ack_bit : '0);

  assign tx_active     = (st == S_RUN);
  assign tx_committing = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      sr           <= '0;
      sm           <= '0;
      pend         <= '0;
      racers_vec   <= '0;
      killers_vec  <= '0;
      abt_out_mask <= '0;
      ack_out_vld  <= 1'b0;
      ack_out_dst  <= '0;
      tx_committed <= 1'b0;
      tx_aborted   <= 1'b0;
      spur_cnt     <= '0;
    end else begin
      tx_committed <= 1'b0;
      tx_aborted   <= 1'b0;
      abt_out_mask <= '0;
      ack_out_vld  <= abt_in_vld;
      ack_out_dst  <= abt_in_src;
      if (spur && spur_cnt != '1) spur_cnt <= spur_cnt + 1'b1;

      case (st)
        S_IDLE: if (tx_begin) st <= S_RUN;
        S_RUN: begin
          if (do_abort) begin
            tx_aborted  <= 1'b1;
            st          <= S_IDLE;
            sr          <= '0;
            sm          <= '0;
            racers_vec  <= '0;
            killers_vec <= '0;
          end else if (commit_req) begin
            if (racers_vec == '0) begin
              tx_committed <= 1'b1;
              st           <= S_IDLE;
              sr           <= '0;
              sm           <= '0;
              killers_vec  <= '0;
            end else begin
              abt_out_mask <= racers_vec;
              pend         <= racers_vec;
              st           <= S_WAIT;
            end
          end else begin
            if (acc_vld && acc_mod)           racers_vec  <= racers_vec | acc_bit;
            if (acc_vld && acc_wr && acc_any) killers_vec <= killers_vec | acc_bit;
            if (loc_rd) sr[loc_line] <= 1'b1;
            if (loc_wr) sm[loc_line] <= 1'b1;
          end
        end
        S_WAIT: begin
          pend <= pend_nx;
          if (pend_nx == '0) begin
            tx_committed <= 1'b1;
            st           <= S_IDLE;
            sr           <= '0;
            sm           <= '0;
            racers_vec   <= '0;
            killers_vec  <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_committed && tx_aborted)); // R9
  AST_CLEAR_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_committed || tx_aborted) |-> (racers_vec == '0 && killers_vec == '0)); // R11
  AST_MASK_IS_RACERS: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_out_mask != '0) |-> (abt_out_mask == racers_vec && tx_committing)); // R7
  AST_ACK_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    abt_in_vld |=> (ack_out_vld && ack_out_dst == $past(abt_in_src))); // R8
  AST_READ_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && acc_vld && !acc_wr && !sm[acc_line] && !do_abort && !commit_req)
      |=> ($stable(racers_vec) && $stable(killers_vec))); // R3
  AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_committing |-> ((pend & ~racers_vec) == '0 && pend != '0)); // R7
  AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && commit_req && !do_abort && racers_vec == '0)
      |=> (tx_committed && abt_out_mask == '0)); // R6

endmodule

// File: tb/test_txn_conflict_tracker.sv
`timescale 1ns/1ps
module test_txn_conflict_tracker;
  localparam int NC = 32, NL = 16, CW = 5, LW = 4, CNTW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_begin = 0, loc_rd = 0, loc_wr = 0, acc_vld = 0, acc_wr = 0;
  logic commit_req = 0, abt_in_vld = 0, ack_in_vld = 0;
  logic [LW-1:0] loc_line = '0, acc_line = '0;
  logic [CW-1:0] acc_core = '0, abt_in_src = '0, ack_in_src = '0;
  logic tx_active, tx_committing, ack_out_vld, tx_committed, tx_aborted;
  logic [NC-1:0] racers_vec, killers_vec, abt_out_mask;
  logic [CW-1:0] ack_out_dst;
  logic [CNTW-1:0] spur_cnt;

  txn_conflict_tracker #(.NCORES(NC), .NLINES(NL), .CNTW(CNTW)) i_txn_conflict_tracker (
    .clk, .rst_n, .tx_begin, .loc_rd, .loc_wr, .loc_line, .acc_vld, .acc_core,
    .acc_line, .acc_wr, .commit_req, .abt_in_vld, .abt_in_src, .ack_in_vld,
    .ack_in_src, .tx_active, .tx_committing, .racers_vec, .killers_vec,
    .abt_out_mask, .ack_out_vld, .ack_out_dst, .tx_committed, .tx_aborted, .spur_cnt);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic [NL-1:0] m_sr = '0, m_sm = '0;
  logic [NC-1:0] m_rac = '0, m_kil = '0, m_pend = '0, e_mask;
  int m_st = 0;
  int m_spur = 0;
  bit e_cmt, e_abt, e_ackv;
  logic [CW-1:0] e_ackd;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] bitof(logic [CW-1:0] c);
    return NC'(1) << c;
  endfunction

  task automatic clr_model();
    m_sr = '0; m_sm = '0; m_rac = '0; m_kil = '0; m_st = 0;
  endtask

  task automatic cyc(bit b, bit rd, bit wr, logic [LW-1:0] ll,
                     bit av, logic [CW-1:0] ac, logic [LW-1:0] al, bit aw,
                     bit cm, bit ab, logic [CW-1:0] as, bit kv, logic [CW-1:0] ks);
    bit hit;
    e_cmt = 0; e_abt = 0; e_mask = '0; e_ackv = ab; e_ackd = as;
    hit = m_kil[as];
    if (ab && !hit && m_spur < 255) m_spur++;
    case (m_st)
      0: if (b) m_st = 1;
      1: begin
        if (ab && hit) begin e_abt = 1; clr_model(); end
        else if (cm) begin
          if (m_rac == '0) begin e_cmt = 1; clr_model(); end
          else begin e_mask = m_rac; m_pend = m_rac; m_st = 2; end
        end else begin
          if (av && m_sm[al]) m_rac |= bitof(ac);
          if (av && aw && (m_sm[al] || m_sr[al])) m_kil |= bitof(ac);
          if (rd) m_sr[ll] = 1'b1;
          if (wr) m_sm[ll] = 1'b1;
        end
      end
      default: begin
        if (kv) m_pend &= ~bitof(ks);
        if (m_pend == '0) begin e_cmt = 1; clr_model(); end
      end
    endcase
    tx_begin = b; loc_rd = rd; loc_wr = wr; loc_line = ll;
    acc_vld = av; acc_core = ac; acc_line = al; acc_wr = aw;
    commit_req = cm; abt_in_vld = ab; abt_in_src = as; ack_in_vld = kv; ack_in_src = ks;
    @(posedge clk); #1;
    tx_begin = 0; loc_rd = 0; loc_wr = 0; acc_vld = 0; commit_req = 0;
    abt_in_vld = 0; ack_in_vld = 0;
    chk("R2", "tx_active", 64'(tx_active), 64'(m_st == 1));
    chk("R7", "tx_committing", 64'(tx_committing), 64'(m_st == 2));
    chk("R4", "racers_vec", 64'(racers_vec), 64'(m_rac));
    chk("R5", "killers_vec", 64'(killers_vec), 64'(m_kil));
    chk("R7", "abt_out_mask", 64'(abt_out_mask), 64'(e_mask));
    chk("R6", "tx_committed", 64'(tx_committed), 64'(e_cmt));
    chk("R9", "tx_aborted", 64'(tx_aborted), 64'(e_abt));
    chk("R8", "ack_out_vld", 64'(ack_out_vld), 64'(e_ackv));
    if (e_ackv) chk("R8", "ack_out_dst", 64'(ack_out_dst), 64'(e_ackd));
    chk("R10", "spur_cnt", 64'(spur_cnt), 64'(m_spur));
  endtask

  task automatic idle1();              cyc(0,0,0,0, 0,0,0,0, 0, 0,0, 0,0); endtask
  task automatic begin_tx();           cyc(1,0,0,0, 0,0,0,0, 0, 0,0, 0,0); endtask
  task automatic lrd(int l);           cyc(0,1,0,LW'(l), 0,0,0,0, 0, 0,0, 0,0); endtask
  task automatic lwr(int l);           cyc(0,0,1,LW'(l), 0,0,0,0, 0, 0,0, 0,0); endtask
  task automatic racc(int c, int l, bit w); cyc(0,0,0,0, 1,CW'(c),LW'(l),w, 0, 0,0, 0,0); endtask
  task automatic commit();             cyc(0,0,0,0, 0,0,0,0, 1, 0,0, 0,0); endtask
  task automatic abort_in(int c);      cyc(0,0,0,0, 0,0,0,0, 0, 1,CW'(c), 0,0); endtask
  task automatic ack_in(int c);        cyc(0,0,0,0, 0,0,0,0, 0, 0,0, 1,CW'(c)); endtask

  initial begin
    #(4*200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk("R1", "idle", 64'(tx_active | tx_committing | tx_committed | tx_aborted | ack_out_vld), 0);
    chk("R1", "vectors", 64'(racers_vec | killers_vec | abt_out_mask), 0);
    chk("R1", "spur_cnt", 64'(spur_cnt), 0);

    // R2: idle write leaves no trace
    lwr(3); begin_tx(); racc(5, 3, 0);
    chk("R2", "idle write ignored", 64'(racers_vec), 0);
    lwr(3); racc(5, 3, 0);
    chk("R4", "racer after WR", 64'(racers_vec), 64'(32'h20));
    // R3: read-read
    lrd(4); racc(6, 4, 0);
    chk("R3", "read-read no killer", 64'(killers_vec), 0);
    chk("R3", "read-read no racer", 64'(racers_vec), 64'(32'h20));
    racc(7, 4, 1);
    chk("R5", "killer after RW", 64'(killers_vec), 64'(32'h80));
    // R10: spurious abort ignored
    abort_in(9);
    chk("R10", "still active", 64'(tx_active), 1);
    chk("R10", "count", 64'(spur_cnt), 1);
    // R9: killer abort beats commit
    cyc(0,0,0,0, 0,0,0,0, 1, 1,CW'(7), 0,0);
    chk("R9", "aborted", 64'(tx_aborted), 1);
    chk("R9", "no commit", 64'(tx_committed), 0);
    // R11: flags cleared
    begin_tx(); racc(2, 4, 1); racc(2, 3, 1);
    chk("R11", "flags cleared", 64'(killers_vec | racers_vec), 0);
    // R6: empty commit
    commit();
    chk("R6", "empty commit done", 64'(tx_committed), 1);
    chk("R6", "no abort mask", 64'(abt_out_mask), 0);
    // R7 / R12
    begin_tx(); lwr(1); racc(3, 1, 1); racc(10, 1, 0);
    commit();
    chk("R7", "mask", 64'(abt_out_mask), 64'(32'h408));
    abort_in(3);
    chk("R12", "not aborted", 64'(tx_aborted), 0);
    chk("R12", "acked", 64'(ack_out_vld), 1);
    ack_in(3);
    chk("R7", "waiting", 64'(tx_committed), 0);
    ack_in(10);
    chk("R12", "commit completes", 64'(tx_committed), 1);
    idle1();

    // random phase
    for (int t = 0; t < 300; t++) begin
      begin_tx();
      for (int k = 0; k < 4 + int'($urandom_range(10)); k++) begin
        if (m_st != 1) break;
        cyc(0, $urandom_range(2) == 0, $urandom_range(2) == 0, LW'($urandom_range(NL-1)),
            $urandom_range(1) == 0, CW'($urandom_range(NC-1)), LW'($urandom_range(NL-1)),
            $urandom_range(1) == 0, 0,
            $urandom_range(9) == 0, CW'($urandom_range(NC-1)), 0, 0);
      end
      if (m_st == 1) commit();
      while (m_st == 2) begin
        logic [CW-1:0] c;
        c = CW'($urandom_range(NC-1));
        if (m_pend[c] && $urandom_range(1) == 0)
          cyc(0,0,0,0, 0,0,0,0, 0, $urandom_range(4) == 0, CW'($urandom_range(NC-1)), 1, c);
        else
          cyc(0,0,0,0, 0,0,0,0, 0, $urandom_range(6) == 0, CW'($urandom_range(NC-1)), 0, 0);
      end
      idle1();
    end

    // R10 saturation
    for (int i = 0; i < 300; i++) abort_in(i % NC);
    chk("R10", "saturated", 64'(spur_cnt), 255);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule